// File: doc/BRIEF.md
# Two-RAM Block Cipher Sequencer

This block sits between a memory-mapped register bus and an external block-cipher core. It holds two block-wide RAMs: a plaintext RAM and a ciphertext RAM. Software fills one of them, sets the start positions of the source and destination areas, a block count and the mode, and then writes the go bit. The sequencer walks the blocks in order. It reads each source block, passes it to the core over a valid/ready port, takes the core's result over a second valid/ready port and writes it to the destination RAM. When the last block is written it raises a done flag and an interrupt.

Encryption moves data from the plaintext RAM to the ciphertext RAM. Decryption moves it the other way. In chained mode the IV register feeds the first block, and each block then chains to the one before it. When the operation ends, the IV register holds the last ciphertext block, so a long message can be processed in several passes. The low part of each RAM is set aside for stored keys. Start positions count blocks from the end of that area. An operation that would run past the top of a RAM is refused. A zeroize command wipes both RAMs.

Back-pressure rules on the core port: `core_in_valid` rises only in the fetch phase, and it stays high with `core_in_data` unchanged until `core_in_ready` is seen. `core_out_ready` is high only while a result is awaited, and one result is taken per block. The core may stall either side for any number of cycles.

Top module: `secmem_cipher`

## Requirements
- R1: After reset, `busy_o` and `irq_o` are low, and the status, control, IV and count registers read zero.
- R2: The read-only config register (index 6) reports bytes per block in bits 6:0, the plaintext RAM depth in blocks in bits 16:7 and the ciphertext RAM depth in blocks in bits 26:17.
- R3: A control write (index 3) with bit 2 set and bits 1:0 = 00 encrypts in ECB mode. Count+1 blocks are read from the plaintext RAM at RSVD+ptstart+i. Each block is sent once to the core, and the result is written to the ciphertext RAM at RSVD+ctstart+i. RSVD is the key-slot area (20 slots of 32 bytes, 80 blocks by default). Register indices: 0 = ptstart, 1 = ctstart, 2 = count.
- R4: With control bit 0 (decrypt) set, blocks are read from the ciphertext RAM and written to the plaintext RAM, and `core_in_dec` is high.
- R5: With control bit 1 (chained) set, encryption sends P xor chain to the core. The chain starts from the IV register (index 7) and becomes each new ciphertext block. After the operation the IV register holds the last ciphertext.
- R6: Chained decryption writes core output xor chain, and the chain becomes each input ciphertext block. After the operation the IV register holds the last input ciphertext.
- R7: `busy_o` is high from the cycle after an accepted go until the cycle after the last result is taken. On that edge, status bit 10 (done) and bit 8 (pending) are set.
- R8: `irq_o` equals pending AND NOT mask, where mask is interrupt-control (index 5) bit 0. Writing bit 1 clears pending, and that bit always reads back 0.
- R9: If ptstart+count or ctstart+count is not below DEPTH-RSVD, the go is refused. Status bit 12 is set, `busy_o` stays low and no RAM is written. An accepted go clears bit 12.
- R10: Writing interrupt-control bit 2 while idle zeroes both RAMs one address per cycle over DEPTH cycles. During that time status bit 1 (and bit 0) is high. Afterwards status bit 9 is set. A go issued during zeroize is ignored.
- R11: `core_in_data` stays stable while `core_in_valid` is high and `core_in_ready` is low. `core_out_ready` is high only while busy.
- R12: While busy, writes to the start, count, control and IV registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bits [ADDR_W-1:ADDR_W-2]: 0 registers, 1 plaintext RAM, 2 ciphertext RAM |
| bus_wdata | input | BLK_W | Bus write data |
| bus_rdata | output | BLK_W | Combinational read data for `bus_addr` |
| core_in_valid | output | 1 | Block offered to the cipher core |
| core_in_ready | input | 1 | Core accepts the block |
| core_in_data | output | BLK_W | Block to the core |
| core_in_dec | output | 1 | Core direction, 1 = decrypt |
| core_out_valid | input | 1 | Core result available |
| core_out_ready | output | 1 | Sequencer takes the result |
| core_out_data | input | BLK_W | Core result |
| busy_o | output | 1 | Cipher operation in progress |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench attacks the chaining corner: a design that chains on the wrong value (plaintext instead of ciphertext, or output instead of input when decrypting) gives a correct first block and wrong blocks after it, and leaves a wrong IV behind. It places ranges exactly on the last legal block and one past it; an off-by-one bounds check either refuses a legal run or writes beyond the data area. It runs with a stub core that stalls its ready input, so a sequencer that moves on without a handshake or changes data while stalled drops or repeats blocks. It also sends go commands during an operation and during zeroize; a design that accepts them restarts mid-run, which shows up as a busy mismatch against the per-clock model.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT, ST_ZERO} seq_st_e;

  localparam logic [2:0] A_PTSTART = 3'd0;
  localparam logic [2:0] A_CTSTART = 3'd1;
  localparam logic [2:0] A_COUNT   = 3'd2;
  localparam logic [2:0] A_CTRL    = 3'd3;
  localparam logic [2:0] A_STAT    = 3'd4;
  localparam logic [2:0] A_ICTL    = 3'd5;
  localparam logic [2:0] A_CFG     = 3'd6;
  localparam logic [2:0] A_IV      = 3'd7;

  localparam logic [1:0] RG_REG = 2'd0;
  localparam logic [1:0] RG_PT  = 2'd1;
  localparam logic [1:0] RG_CT  = 2'd2;

  localparam int CB_DEC = 0;
  localparam int CB_CBC = 1;
  localparam int CB_GO  = 2;

  localparam int SB_BUSY  = 0;
  localparam int SB_ZING  = 1;
  localparam int SB_CIPH  = 2;
  localparam int SB_PEND  = 8;
  localparam int SB_ZDONE = 9;
  localparam int SB_CDONE = 10;
  localparam int SB_LERR  = 12;

  localparam int IB_MASK = 0;
  localparam int IB_CLR  = 1;
  localparam int IB_ZERO = 2;
endpackage

// File: rtl/smc_ram.sv
module smc_ram #(
  parameter int DEPTH = 128,
  parameter int W     = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr_a,
  output logic [W-1:0]             rdata_a,
  input  logic [$clog2(DEPTH)-1:0] raddr_b,
  output logic [W-1:0]             rdata_b
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/smc_seq.sv
module smc_seq import smc_pkg::*; #(
  parameter int DEPTH = 128,
  parameter int W     = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          zstart,
  input  logic          dec,
  input  logic          cbc,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [AW-1:0] last_idx,
  input  logic [W-1:0]  src_rdata,
  input  logic [W-1:0]  chain_q,
  output logic [AW-1:0] src_raddr,
  output logic          dst_we,
  output logic [AW-1:0] dst_waddr,
  output logic [W-1:0]  dst_wdata,
  output logic          zero_we,
  output logic [AW-1:0] zero_addr,
  output logic          chain_we,
  output logic [W-1:0]  chain_d,
  output logic          op_done,
  output logic          zero_done,
  output logic          ciphering,
  output logic          zeroizing,
  output logic          core_in_valid,
  input  logic          core_in_ready,
  output logic [W-1:0]  core_in_data,
  output logic          core_in_dec,
  input  logic          core_out_valid,
  output logic          core_out_ready,
  input  logic [W-1:0]  core_out_data
);
  seq_st_e       st_q;
  logic [AW-1:0] idx_q;
  logic [AW-1:0] zaddr_q;
  logic [W-1:0]  held_q;
  logic          take;

  assign ciphering      = (st_q == ST_FETCH) || (st_q == ST_WAIT);
  assign zeroizing      = (st_q == ST_ZERO);
  assign src_raddr      = src_base + idx_q;
  assign core_in_valid  = (st_q == ST_FETCH);
  assign core_in_data   = (cbc && !dec) ? (src_rdata ^ chain_q) : src_rdata;
  assign core_in_dec    = dec;
  assign core_out_ready = (st_q == ST_WAIT);
  assign take           = core_out_valid && core_out_ready;

  assign dst_we    = take;
  assign dst_waddr = dst_base + idx_q;
  assign dst_wdata = (cbc && dec) ? (core_out_data ^ chain_q) : core_out_data;
  assign chain_we  = take && cbc;
  assign chain_d   = dec ? held_q : core_out_data;
  assign op_done   = take && (idx_q == last_idx);

  assign zero_we   = zeroizing;
  assign zero_addr = zaddr_q;
  assign zero_done = zeroizing && (zaddr_q == AW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      zaddr_q <= '0;
      held_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (zstart) begin
            st_q    <= ST_ZERO;
            zaddr_q <= '0;
          end else if (start) begin
            st_q  <= ST_FETCH;
            idx_q <= '0;
          end
        end
        ST_FETCH: begin
          if (core_in_ready) begin
            held_q <= src_rdata;
            st_q   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (core_out_valid) begin
            if (idx_q == last_idx) st_q <= ST_IDLE;
            else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= ST_FETCH;
            end
          end
        end
        default: begin
          zaddr_q <= zaddr_q + 1'b1;
          if (zero_done) st_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/secmem_cipher.sv
module secmem_cipher import smc_pkg::*; #(
  parameter int BLK_W      = 64,
  parameter int DEPTH      = 128,
  parameter int KEY_SLOTS  = 20,
  parameter int SLOT_BYTES = 32,
  parameter int ADDR_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BLK_W-1:0]  bus_wdata,
  output logic [BLK_W-1:0]  bus_rdata,
  output logic              core_in_valid,
  input  logic              core_in_ready,
  output logic [BLK_W-1:0]  core_in_data,
  output logic              core_in_dec,
  input  logic              core_out_valid,
  output logic              core_out_ready,
  input  logic [BLK_W-1:0]  core_out_data,
  output logic              busy_o,
  output logic              irq_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int RSVD = KEY_SLOTS * SLOT_BYTES / (BLK_W / 8);
  localparam int DATA = DEPTH - RSVD;

  logic [AW-1:0]    ptstart_q, ctstart_q, count_q;
  logic [1:0]       ctrl_q;
  logic [BLK_W-1:0] iv_q;
  logic             mask_q, pend_q, cdone_q, zdone_q, lerr_q;

  logic [1:0]       region;
  logic [2:0]       sel;
  logic             wr_reg, idle, go_req, fits, start, zstart, clr_req;
  logic [AW:0]      pt_end, ct_end;

  logic [AW-1:0]    src_raddr, dst_waddr, zero_addr;
  logic [BLK_W-1:0] dst_wdata, chain_d, src_rdata;
  logic             dst_we, zero_we, chain_we, op_done, zero_done, ciphering, zeroizing;
  logic [BLK_W-1:0] rd_bus [2];
  logic [BLK_W-1:0] rd_seq [2];

  assign region  = bus_addr[ADDR_W-1 -: 2];
  assign sel     = bus_addr[2:0];
  assign idle    = !ciphering && !zeroizing;
  assign wr_reg  = bus_we && (region == RG_REG);
  assign go_req  = wr_reg && (sel == A_CTRL) && bus_wdata[CB_GO] && idle;
  assign pt_end  = {1'b0, ptstart_q} + {1'b0, count_q};
  assign ct_end  = {1'b0, ctstart_q} + {1'b0, count_q};
  assign fits    = (pt_end < (AW+1)'(DATA)) && (ct_end < (AW+1)'(DATA));
  assign start   = go_req && fits;
  assign zstart  = wr_reg && (sel == A_ICTL) && bus_wdata[IB_ZERO] && idle;
  assign clr_req = wr_reg && (sel == A_ICTL) && bus_wdata[IB_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptstart_q <= '0;
      ctstart_q <= '0;
      count_q   <= '0;
      ctrl_q    <= '0;
      iv_q      <= '0;
      mask_q    <= 1'b0;
      pend_q    <= 1'b0;
      cdone_q   <= 1'b0;
      zdone_q   <= 1'b0;
      lerr_q    <= 1'b0;
    end else begin
      if (wr_reg && idle) begin
        case (sel)
          A_PTSTART: ptstart_q <= bus_wdata[AW-1:0];
          A_CTSTART: ctstart_q <= bus_wdata[AW-1:0];
          A_COUNT:   count_q   <= bus_wdata[AW-1:0];
          A_CTRL:    ctrl_q    <= bus_wdata[1:0];
          default: ;
        endcase
      end
      if (chain_we) iv_q <= chain_d;
      else if (wr_reg && idle && (sel == A_IV)) iv_q <= bus_wdata;
      if (wr_reg && (sel == A_ICTL)) mask_q <= bus_wdata[IB_MASK];
      pend_q  <= op_done || (pend_q && !clr_req);
      cdone_q <= op_done || (cdone_q && !start);
      zdone_q <= zero_done || (zdone_q && !zstart);
      if (go_req) lerr_q <= !fits;
    end
  end

  smc_seq #(.DEPTH(DEPTH), .W(BLK_W)) u_seq (
    .clk, .rst_n, .start, .zstart,
    .dec       (ctrl_q[CB_DEC]),
    .cbc       (ctrl_q[CB_CBC]),
    .src_base  (AW'(RSVD) + (ctrl_q[CB_DEC] ? ctstart_q : ptstart_q)),
    .dst_base  (AW'(RSVD) + (ctrl_q[CB_DEC] ? ptstart_q : ctstart_q)),
    .last_idx  (count_q),
    .src_rdata, .chain_q (iv_q), .src_raddr,
    .dst_we, .dst_waddr, .dst_wdata, .zero_we, .zero_addr,
    .chain_we, .chain_d, .op_done, .zero_done, .ciphering, .zeroizing,
    .core_in_valid, .core_in_ready, .core_in_data, .core_in_dec,
    .core_out_valid, .core_out_ready, .core_out_data
  );

  // g = 0: plaintext RAM, g = 1: ciphertext RAM
  for (genvar g = 0; g < 2; g++) begin : g_ram
    logic             is_dst, bus_hit, we;
    logic [AW-1:0]    waddr;
    logic [BLK_W-1:0] wdata;
    assign is_dst  = (g == 1) ? !ctrl_q[CB_DEC] : ctrl_q[CB_DEC];
    assign bus_hit = bus_we && idle && (region == 2'(g + 1));
    assign we      = zero_we || (dst_we && is_dst) || bus_hit;
    assign waddr   = zero_we ? zero_addr : ((dst_we && is_dst) ? dst_waddr : bus_addr[AW-1:0]);
    assign wdata   = zero_we ? '0 : ((dst_we && is_dst) ? dst_wdata : bus_wdata);
    smc_ram #(.DEPTH(DEPTH), .W(BLK_W)) u_ram (
      .clk, .we, .waddr, .wdata,
      .raddr_a (bus_addr[AW-1:0]), .rdata_a (rd_bus[g]),
      .raddr_b (src_raddr),        .rdata_b (rd_seq[g])
    );
  end

  assign src_rdata = ctrl_q[CB_DEC] ? rd_seq[1] : rd_seq[0];

  always_comb begin
    bus_rdata = '0;
    case (region)
      RG_REG: begin
        case (sel)
          A_PTSTART: bus_rdata = BLK_W'(ptstart_q);
          A_CTSTART: bus_rdata = BLK_W'(ctstart_q);
          A_COUNT:   bus_rdata = BLK_W'(count_q);
          A_CTRL:    bus_rdata = BLK_W'(ctrl_q);
          A_STAT: begin
            bus_rdata[SB_BUSY]  = ciphering || zeroizing;
            bus_rdata[SB_ZING]  = zeroizing;
            bus_rdata[SB_CIPH]  = ciphering;
            bus_rdata[SB_PEND]  = pend_q;
            bus_rdata[SB_ZDONE] = zdone_q;
            bus_rdata[SB_CDONE] = cdone_q;
            bus_rdata[SB_LERR]  = lerr_q;
          end
          A_ICTL: bus_rdata[IB_MASK] = mask_q;
          A_CFG: begin
            bus_rdata[6:0]   = 7'(BLK_W / 8);
            bus_rdata[16:7]  = 10'(DEPTH);
            bus_rdata[26:17] = 10'(DEPTH);
          end
          default: bus_rdata = iv_q;
        endcase
      end
      RG_PT:   bus_rdata = rd_bus[0];
      RG_CT:   bus_rdata = rd_bus[1];
      default: bus_rdata = '0;
    endcase
  end

  assign busy_o = ciphering;
  assign irq_o  = pend_q && !mask_q;
endmodule

// File: rtl/secmem_cipher_chk.sv
module secmem_cipher_chk #(
  parameter int BLK_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             core_in_valid,
  input logic             core_in_ready,
  input logic [BLK_W-1:0] core_in_data,
  input logic             core_out_ready,
  input logic             zeroizing,
  input logic             pend_q,
  input logic             lerr_q
);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    core_in_valid && !core_in_ready |=> core_in_valid && $stable(core_in_data));

  p_oready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    core_out_ready |-> busy_o);

  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> pend_q);

  p_pend_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $fell(busy_o));

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, zeroizing}));

  p_lerr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lerr_q) |-> !busy_o);
endmodule

bind secmem_cipher secmem_cipher_chk #(.BLK_W(BLK_W)) u_chk (
  .clk, .rst_n, .busy_o, .core_in_valid, .core_in_ready, .core_in_data,
  .core_out_ready, .zeroizing, .pend_q, .lerr_q
);

// File: tb/secmem_cipher_tb.sv
module secmem_cipher_tb;
  localparam logic [63:0] KEY = 64'h5A3C_96F0_0FF0_C3A5;
  localparam int RSVD = 80;
  localparam int DEPTH = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [8:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic core_in_valid, core_in_ready, core_in_dec, core_out_valid, core_out_ready;
  logic [63:0] core_in_data, core_out_data;
  logic busy_o, irq_o;

  always #10 clk = ~clk;

  secmem_cipher u_dut (
    .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .core_in_valid, .core_in_ready, .core_in_data, .core_in_dec,
    .core_out_valid, .core_out_ready, .core_out_data, .busy_o, .irq_o
  );

  // cipher core stub: XOR with KEY, one entry, stalls its input side
  logic full = 1'b0;
  logic [63:0] sdata = '0;
  int cyc = 0;
  assign core_in_ready  = !full && (cyc % 3 != 1);
  assign core_out_valid = full;
  assign core_out_data  = sdata;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) full <= 1'b0;
    else if (core_in_valid && core_in_ready) begin
      full <= 1'b1;
      sdata <= core_in_data ^ KEY;
    end else if (core_out_valid && core_out_ready) full <= 1'b0;
  end

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model, updated on every edge
  bit m_busy = 0, m_pend = 0, m_mask = 0, m_zero = 0;
  int m_left = 0, m_zc = 0, m_rs = 0, m_bs = 0, m_ln = 0;
  always @(posedge clk) begin
    bit idle_pre, take, fin, clr;
    if (!rst_n) begin
      m_busy = 0; m_pend = 0; m_mask = 0; m_zero = 0;
      m_rs = 0; m_bs = 0; m_ln = 0;
    end else begin
      idle_pre = !m_busy && !m_zero;
      take = core_out_valid && core_out_ready;
      fin = 0;
      clr = 0;
      if (m_zero) begin
        m_zc--;
        if (m_zc == 0) m_zero = 0;
      end
      if (m_busy && take) begin
        m_left--;
        if (m_left == 0) begin m_busy = 0; fin = 1; end
      end
      if (bus_we && bus_addr[8:7] == 2'd0) begin
        case (bus_addr[2:0])
          3'd0: if (idle_pre) m_rs = int'(bus_wdata[6:0]);
          3'd1: if (idle_pre) m_bs = int'(bus_wdata[6:0]);
          3'd2: if (idle_pre) m_ln = int'(bus_wdata[6:0]);
          3'd3: if (idle_pre && bus_wdata[2] && m_rs + m_ln < DEPTH - RSVD && m_bs + m_ln < DEPTH - RSVD) begin
                  m_busy = 1; m_left = m_ln + 1;
                end
          3'd5: begin
                  m_mask = bus_wdata[0];
                  clr = bus_wdata[1];
                  if (bus_wdata[2] && idle_pre) begin m_zero = 1; m_zc = DEPTH; end
                end
          default: ;
        endcase
      end
      m_pend = fin || (m_pend && !clr);
    end
  end

  bit p_iv = 0, p_ir = 0;
  logic [63:0] p_id = '0;
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk(busy_o === m_busy, "R7 busy vs model", 64'(busy_o), 64'(m_busy));
      chk(irq_o === (m_pend && !m_mask), "R8 irq vs model", 64'(irq_o), 64'(m_pend && !m_mask));
      if (p_iv && !p_ir)
        chk(core_in_valid && core_in_data === p_id, "R11 stall hold", core_in_data, p_id);
      if (core_out_ready) chk(busy_o, "R11 out_ready only when busy", 64'(busy_o), 64'd1);
    end
    p_iv = core_in_valid; p_ir = core_in_ready; p_id = core_in_data;
  end

  function automatic logic [8:0] ra(input int i); return 9'(i); endfunction
  function automatic logic [8:0] pa(input int i); return 9'h080 | 9'(i); endfunction
  function automatic logic [8:0] ca(input int i); return 9'h100 | 9'(i); endfunction
  function automatic logic [63:0] pat(input int i);
    return {32'hCAFE_0000 + 32'(i), 32'h0BAD_0000 + 32'(i * 7)};
  endfunction

  task automatic wr(input logic [8:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  logic [63:0] v, chain, lastc;
  logic [63:0] cexp [4];

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o && !irq_o, "R1 busy/irq after reset", {busy_o, irq_o}, 64'd0);
    rd(ra(4), v); chk(v == 64'd0, "R1 status reset", v, 0);
    rd(ra(3), v); chk(v == 64'd0, "R1 ctrl reset", v, 0);
    rd(ra(7), v); chk(v == 64'd0, "R1 iv reset", v, 0);
    rd(ra(2), v); chk(v == 64'd0, "R1 count reset", v, 0);
    // R2 config layout
    rd(ra(6), v);
    chk(v == (64'd8 | (64'd128 << 7) | (64'd128 << 17)), "R2 config",
        v, (64'd8 | (64'd128 << 7) | (64'd128 << 17)));

    // R3 ECB encrypt, 4 blocks, pt 0 -> ct 2
    for (int i = 0; i < 4; i++) wr(pa(RSVD + i), pat(i));
    wr(ra(0), 0); wr(ra(1), 2); wr(ra(2), 3);
    wr(ra(3), 64'h4);
    wait_idle();
    for (int i = 0; i < 4; i++) begin
      rd(ca(RSVD + 2 + i), v); chk(v == (pat(i) ^ KEY), "R3 ecb enc block", v, pat(i) ^ KEY);
    end
    rd(ra(4), v); chk(v[10] && v[8] && !v[0], "R7 done+pending set", v, 64'h500);
    chk(irq_o, "R8 irq raised unmasked", 64'(irq_o), 1);
    wr(ra(5), 64'h2);
    rd(ra(4), v); chk(!v[8], "R8 clear pending", v, 0);
    rd(ra(5), v); chk(v == 64'd0, "R8 clear bit self-clears", v, 0);
    chk(!irq_o, "R8 irq dropped", 64'(irq_o), 0);

    // R4 ECB decrypt ct 2 -> pt 10, masked
    wr(ra(5), 64'h1);
    wr(ra(0), 10); wr(ra(1), 2); wr(ra(2), 1);
    wr(ra(3), 64'h5);
    @(negedge clk);
    chk(core_in_dec, "R4 core direction decrypt", 64'(core_in_dec), 1);
    wait_idle();
    for (int i = 0; i < 2; i++) begin
      rd(pa(RSVD + 10 + i), v); chk(v == pat(i), "R4 ecb dec block", v, pat(i));
    end
    rd(ra(4), v); chk(v[8] && !irq_o, "R8 masked pending no irq", {v[8], irq_o}, 64'h2);
    wr(ra(5), 64'h0);
    chk(irq_o, "R8 unmask raises irq", 64'(irq_o), 1);
    wr(ra(5), 64'h2);

    // R5 CBC encrypt pt 20 -> ct 20
    for (int i = 0; i < 4; i++) wr(pa(RSVD + 20 + i), pat(i + 40));
    wr(ra(7), 64'h0123_4567_89AB_CDEF);
    wr(ra(0), 20); wr(ra(1), 20); wr(ra(2), 3);
    wr(ra(3), 64'h6);
    wait_idle();
    chain = 64'h0123_4567_89AB_CDEF;
    for (int i = 0; i < 4; i++) begin
      cexp[i] = (pat(i + 40) ^ chain) ^ KEY;
      chain = cexp[i];
      rd(ca(RSVD + 20 + i), v); chk(v == cexp[i], "R5 cbc enc block", v, cexp[i]);
    end
    rd(ra(7), v); chk(v == cexp[3], "R5 iv holds last ciphertext", v, cexp[3]);

    // R6 CBC decrypt ct 20 -> pt 30
    wr(ra(7), 64'h0123_4567_89AB_CDEF);
    wr(ra(0), 30); wr(ra(1), 20); wr(ra(2), 3);
    wr(ra(3), 64'h7);
    wait_idle();
    for (int i = 0; i < 4; i++) begin
      rd(pa(RSVD + 30 + i), v); chk(v == pat(i + 40), "R6 cbc dec block", v, pat(i + 40));
    end
    rd(ra(7), v); chk(v == cexp[3], "R6 iv holds last input ciphertext", v, cexp[3]);

    // R9 length error: pt 45 + 3 = 48 out of range
    wr(ca(RSVD), 64'hDEAD_BEEF_0000_1111);
    wr(ra(0), 45); wr(ra(1), 0); wr(ra(2), 3);
    wr(ra(3), 64'h4);
    @(negedge clk);
    chk(!busy_o, "R9 refused go stays idle", 64'(busy_o), 0);
    rd(ra(4), v); chk(v[12] && !v[0], "R9 length error flag", v, 64'h1000);
    rd(ca(RSVD), v); chk(v == 64'hDEAD_BEEF_0000_1111, "R9 no RAM write", v, 64'hDEAD_BEEF_0000_1111);
    // R9 boundary: pt 44 + 3 = 47 accepted, ct 44..47
    wr(ra(0), 44); wr(ra(1), 44);
    wr(ra(3), 64'h4);
    // R12: writes while busy ignored
    wr(ra(2), 0);
    wr(ra(3), 64'h5);
    wait_idle();
    rd(ra(2), v); chk(v == 64'd3, "R12 count write ignored while busy", v, 3);
    rd(ra(3), v); chk(v == 64'd0, "R12 ctrl write ignored while busy", v, 0);
    rd(ra(4), v); chk(!v[12] && v[10], "R9 accepted go clears error", v, 64'h400);
    rd(pa(RSVD + 47), v);
    rd(ca(RSVD + 47), bus_wdata);
    chk(bus_wdata == (v ^ KEY), "R9 last legal block processed", bus_wdata, v ^ KEY);
    bus_wdata = '0;
    wr(ra(5), 64'h2);

    // R10 zeroize, with a go attempted during it
    wr(ra(5), 64'h4);
    rd(ra(4), v); chk(v[1] && v[0], "R10 zeroizing status", v, 64'h3);
    wr(ra(0), 0); wr(ra(2), 0);
    wr(ra(3), 64'h4);
    chk(!busy_o, "R10 go ignored during zeroize", 64'(busy_o), 0);
    repeat (DEPTH + 2) @(negedge clk);
    rd(ra(4), v); chk(v[9] && !v[1], "R10 zeroize done", v, 64'h200);
    rd(pa(RSVD + 30), v); chk(v == 0, "R10 pt RAM cleared", v, 0);
    rd(ca(RSVD + 47), v); chk(v == 0, "R10 ct RAM cleared", v, 0);
    rd(pa(0), v); chk(v == 0, "R10 key area cleared", v, 0);
    rd(ca(RSVD), v); chk(v == 0, "R10 ct marker cleared", v, 0);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R7 actual=%h expected=%h", 64'd0, 64'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule